// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Boundary Counter

This block keeps a free-running multiframe counter in the link clock domain. It lets a SYSREF pulse realign that counter, so that every device sharing the same SYSREF places its multiframe boundary at the same instant. One multiframe covers 8 octets per frame times 32 frames, which is 256 octets. With 8 octets handled per link clock, the counter wraps every 32 clocks. It raises a one-cycle boundary strobe at count zero.

Each rising SYSREF edge is located against the local boundary. The offset is published as a phase value, and zero means aligned. Realignment uses the integer mean of 2^`cfg_avg_sel` consecutive phase readings. It happens either on every group of edges (continuous mode) or once after software arms the block (one-shot mode). In one-shot mode the arm bit clears itself when the alignment is done. A sticky flag records that an alignment has happened since the last arm write.

The controller has three states:
- `ST_IDLE`: one-shot mode with the arm bit low. Edges are measured but not counted.
- `ST_GATHER`: edges are collected into the current group.
- `ST_LOCKED`: a one-shot alignment has completed.

Its transitions are:
- IDLE→GATHER and LOCKED→GATHER on an arm write or when continuous mode is selected.
- GATHER→LOCKED on the final edge of a group in one-shot mode.
- GATHER→GATHER on that same final edge in continuous mode, or on an arm write, which restarts the group.
- GATHER→IDLE when one-shot mode is selected while the arm bit is low.

Top module: `mfc_align_top`

## Requirements
- R1: The counter counts 0 to 31 and wraps. `mf_strobe` is high for exactly the one cycle in which the count is 0. The first cycle after reset release shows the strobe, and strobes repeat every 32 clocks when no realignment occurs.
- R2: SYSREF is registered once, and a rising edge is recognised in the cycle after the first clock edge that samples it high (the detect cycle). A level held high yields only one edge.
- R3: On every detected edge, whatever the mode or state, `phase_value` takes the counter value of the detect cycle, visible one clock later. The value is 0 when the detect cycle is a strobe cycle.
- R4: `phase_nonzero` is 1 exactly when the published phase is not 0.
- R5: A realignment sets the effective count of the detect cycle to (last phase − mean phase) mod 32. When all phases in the group are equal, the next strobe falls 32 clocks after the detect cycle.
- R6: With `cfg_oneshot`=0, every completed group of edges realigns, and no arm write is needed.
- R7: With `cfg_oneshot`=1, edges realign only while armed. Completion clears `arm_status`, and later edges change the phase but never move the strobe.
- R8: A group holds 2^`cfg_avg_sel` edges and its mean is the floor of the sum divided by the count. Earlier edges of a group never move the strobe.
- R9: `aligned_sticky` becomes 1 on a realignment and returns to 0 on an arm write.
- R10: An arm write discards the edges already collected in the current group.
- R11: Reset leaves `phase_value`=0, `phase_nonzero`=0, `arm_status`=0 and `aligned_sticky`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_in | input | 1 | SYSREF, synchronous to clk |
| cfg_arm_set | input | 1 | One-cycle write that sets the arm bit |
| cfg_oneshot | input | 1 | 1 = one-shot mode, 0 = continuous mode |
| cfg_avg_sel | input | 2 | log2 of the number of edges averaged |
| arm_status | output | 1 | Arm bit readback |
| aligned_sticky | output | 1 | Alignment occurred since last arm write |
| phase_value | output | 5 | Counter value at the latest SYSREF detect |
| phase_nonzero | output | 1 | Published phase differs from zero |
| mf_strobe | output | 1 | Boundary strobe, one cycle per wrap |

## Verification
The hardest situation to reach is a realignment whose shift differs from the last edge's own phase. This only happens when an averaged group holds unequal phases. The bench places each SYSREF edge a chosen number of cycles after an observed strobe, which gives phases 4, 6, 8 and 10 in one group of four. It then times the next strobe, which is expected 30 clocks after the drive cycle, while earlier edges must leave the strobe grid unmoved. A second group is entered with SYSREF held high for 80 cycles, to show that a held level advances the group only once.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_LOCKED = 2'd2
    } mfc_state_e;
endpackage

// File: rtl/mfc_sysref_edge.sv
module mfc_sysref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic edge_det
);
    logic samp_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= sysref_in;
            prev_q <= samp_q;
        end
    end

    assign edge_det = samp_q & ~prev_q;

    // two detections can never be adjacent: a level yields one edge
    assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> !edge_det);
endmodule

// File: rtl/mfc_mf_counter.sv
module mfc_mf_counter #(
    parameter int PERIOD = 32,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] shift,
    output logic [CNT_W-1:0] cnt,
    output logic             strobe
);
    localparam int SW = CNT_W + 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [SW-1:0]    raw;
    logic [CNT_W-1:0] reload;

    always_comb begin
        raw = SW'(cnt) + SW'(PERIOD + 1) - SW'(shift);
        if (raw >= SW'(2 * PERIOD))
            reload = CNT_W'(raw - SW'(2 * PERIOD));
        else if (raw >= SW'(PERIOD))
            reload = CNT_W'(raw - SW'(PERIOD));
        else
            reload = CNT_W'(raw);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= reload;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign strobe = (cnt == '0);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == LAST) |=> cnt == '0);
    assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !load) |=> !strobe);
endmodule

// File: rtl/mfc_phase_avg.sv
module mfc_phase_avg #(
    parameter int CNT_W = 5,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [CNT_W-1:0] phase,
    input  logic [SEL_W-1:0] sel,
    output logic             last,
    output logic [CNT_W-1:0] avg
);
    localparam int MAX_LOG = (1 << SEL_W) - 1;
    localparam int ACC_W   = CNT_W + MAX_LOG;
    localparam int CW      = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [CW-1:0]    seen_q;
    logic [CW-1:0]    goal;

    always_comb begin
        goal = CW'((1 << sel) - 1);
        sum  = acc_q + ACC_W'(phase);
        avg  = CNT_W'(sum >> sel);
        last = take && (seen_q == goal);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            seen_q <= '0;
        end else if (take) begin
            if (last) begin
                acc_q  <= '0;
                seen_q <= '0;
            end else begin
                acc_q  <= sum;
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    assert_group_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last && !clear) |=> seen_q == $past(seen_q) + 1'b1);
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
    import mfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_det,
    input  logic oneshot,
    input  logic arm_set,
    input  logic last,
    output logic take,
    output logic apply,
    output logic clear,
    output logic arm_q,
    output logic aligned_q
);
    mfc_state_e state_q;
    mfc_state_e state_d;

    assign take  = edge_det && (state_q == ST_GATHER) && !arm_set;
    assign apply = last;
    assign clear = arm_set || (state_q != ST_GATHER);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_set || !oneshot)
                    state_d = ST_GATHER;
            end
            ST_GATHER: begin
                if (arm_set)
                    state_d = ST_GATHER;
                else if (apply)
                    state_d = oneshot ? ST_LOCKED : ST_GATHER;
                else if (oneshot && !arm_q)
                    state_d = ST_IDLE;
            end
            ST_LOCKED: begin
                if (arm_set || !oneshot)
                    state_d = ST_GATHER;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q     <= 1'b0;
            aligned_q <= 1'b0;
        end else begin
            if (arm_set)
                arm_q <= 1'b1;
            else if (apply && oneshot)
                arm_q <= 1'b0;
            if (arm_set)
                aligned_q <= 1'b0;
            else if (apply)
                aligned_q <= 1'b1;
        end
    end

    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && oneshot) |=> !arm_q);
    assert_sticky_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> aligned_q);
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_GATHER) |-> !apply);
endmodule

// File: rtl/mfc_align_top.sv
module mfc_align_top #(
    parameter int OCTETS_PER_FRAME = 8,
    parameter int FRAMES_PER_MF    = 32,
    parameter int OCTETS_PER_CLK   = 8,
    parameter int AVG_SEL_W        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sysref_in,
    input  logic                 cfg_arm_set,
    input  logic                 cfg_oneshot,
    input  logic [AVG_SEL_W-1:0] cfg_avg_sel,
    output logic                 arm_status,
    output logic                 aligned_sticky,
    output logic [$clog2(OCTETS_PER_FRAME*FRAMES_PER_MF/OCTETS_PER_CLK)-1:0] phase_value,
    output logic                 phase_nonzero,
    output logic                 mf_strobe
);
    localparam int PERIOD = OCTETS_PER_FRAME * FRAMES_PER_MF / OCTETS_PER_CLK;
    localparam int CNT_W  = $clog2(PERIOD);

    logic             edge_det;
    logic             take;
    logic             apply;
    logic             clear;
    logic             last;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] avg;

    mfc_sysref_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sysref_in(sysref_in),
        .edge_det (edge_det)
    );

    mfc_mf_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (apply),
        .shift (avg),
        .cnt   (cnt),
        .strobe(mf_strobe)
    );

    mfc_phase_avg #(.CNT_W(CNT_W), .SEL_W(AVG_SEL_W)) u_avg (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear),
        .take (take),
        .phase(cnt),
        .sel  (cfg_avg_sel),
        .last (last),
        .avg  (avg)
    );

    mfc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_det (edge_det),
        .oneshot  (cfg_oneshot),
        .arm_set  (cfg_arm_set),
        .last     (last),
        .take     (take),
        .apply    (apply),
        .clear    (clear),
        .arm_q    (arm_status),
        .aligned_q(aligned_sticky)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_value   <= '0;
            phase_nonzero <= 1'b0;
        end else if (edge_det) begin
            phase_value   <= cnt;
            phase_nonzero <= (cnt != '0);
        end
    end

    assert_phase_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> phase_value == $past(cnt));
    assert_load_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> edge_det);
endmodule

// File: tb/mfc_align_top_tb.sv
module mfc_align_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sysref_in = 1'b0;
    logic       cfg_arm_set = 1'b0;
    logic       cfg_oneshot = 1'b0;
    logic [1:0] cfg_avg_sel = 2'd0;
    logic       arm_status;
    logic       aligned_sticky;
    logic [4:0] phase_value;
    logic       phase_nonzero;
    logic       mf_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfc_align_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sysref_in     (sysref_in),
        .cfg_arm_set   (cfg_arm_set),
        .cfg_oneshot   (cfg_oneshot),
        .cfg_avg_sel   (cfg_avg_sel),
        .arm_status    (arm_status),
        .aligned_sticky(aligned_sticky),
        .phase_value   (phase_value),
        .phase_nonzero (phase_nonzero),
        .mf_strobe     (mf_strobe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arm_write();
        @(negedge clk);
        cfg_arm_set = 1'b1;
        @(negedge clk);
        cfg_arm_set = 1'b0;
    endtask

    // wait for a strobe, wait d cycles, raise SYSREF for hold cycles;
    // k = cycles from the drive cycle to the next strobe
    task automatic fire(input int d, input int hold, output int k);
        int found;
        found = 0;
        k = -1;
        do @(negedge clk); while (mf_strobe !== 1'b1);
        repeat (d) @(negedge clk);
        sysref_in = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (i == hold) sysref_in = 1'b0;
            if (found == 0 && mf_strobe) begin
                found = 1;
                k = i;
            end
            if (found == 1 && i >= hold) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 first strobe", mf_strobe, 1);
        chk("R11 phase", phase_value, 0);
        chk("R11 nonzero", phase_nonzero, 0);
        chk("R11 arm", arm_status, 0);
        chk("R11 sticky", aligned_sticky, 0);
    endtask

    task automatic t_period();
        int gap;
        do @(negedge clk); while (mf_strobe !== 1'b1);
        for (int r = 0; r < 3; r++) begin
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
                if (gap == 1) chk("R1 strobe width", mf_strobe, 0);
            end while (mf_strobe !== 1'b1);
            chk("R1 period", gap, 32);
        end
    endtask

    task automatic t_continuous();
        int k;
        cfg_oneshot = 1'b0;
        cfg_avg_sel = 2'd0;
        fire(9, 2, k);
        chk("R5 R6 realign gap", k, 33);
        chk("R3 phase", phase_value, 10);
        chk("R4 nonzero set", phase_nonzero, 1);
        fire(31, 2, k);
        chk("R3 aligned phase", phase_value, 0);
        chk("R4 nonzero clear", phase_nonzero, 0);
        chk("R6 steady gap", k, 1);
    endtask

    task automatic t_oneshot();
        int k;
        @(negedge clk);
        cfg_oneshot = 1'b1;
        fire(4, 2, k);
        chk("R7 unarmed no move", k, 28);
        chk("R3 phase unarmed", phase_value, 5);
        arm_write();
        chk("R7 arm set", arm_status, 1);
        fire(4, 2, k);
        chk("R7 armed realign", k, 33);
        chk("R7 arm cleared", arm_status, 0);
        chk("R9 sticky set", aligned_sticky, 1);
        fire(6, 2, k);
        chk("R7 later edge no move", k, 26);
        chk("R7 later phase", phase_value, 7);
        chk("R9 sticky held", aligned_sticky, 1);
    endtask

    task automatic t_average();
        int k;
        cfg_avg_sel = 2'd2;
        arm_write();
        chk("R9 sticky cleared", aligned_sticky, 0);
        fire(3, 2, k);
        chk("R8 edge1 no move", k, 29);
        fire(5, 2, k);
        chk("R8 edge2 no move", k, 27);
        fire(7, 2, k);
        chk("R8 edge3 no move", k, 25);
        chk("R8 edge3 phase", phase_value, 8);
        chk("R8 still armed", arm_status, 1);
        chk("R8 not aligned yet", aligned_sticky, 0);
        fire(9, 2, k);
        chk("R8 R5 mean shift", k, 30);
        chk("R8 phase4", phase_value, 10);
        chk("R8 arm cleared", arm_status, 0);
        chk("R8 aligned", aligned_sticky, 1);
    endtask

    task automatic t_level();
        int k;
        cfg_avg_sel = 2'd1;
        arm_write();
        fire(0, 80, k);
        chk("R2 held level no move", k, 32);
        chk("R2 phase", phase_value, 1);
        chk("R2 one edge counted", arm_status, 1);
        chk("R2 not aligned", aligned_sticky, 0);
        fire(0, 2, k);
        chk("R2 second edge completes", k, 33);
        chk("R2 arm cleared", arm_status, 0);
    endtask

    task automatic t_rearm();
        int k;
        cfg_avg_sel = 2'd1;
        arm_write();
        fire(2, 2, k);
        chk("R10 first edge", k, 30);
        arm_write();
        chk("R9 cleared by arm", aligned_sticky, 0);
        fire(2, 2, k);
        chk("R10 group restarted", k, 30);
        chk("R10 still armed", arm_status, 1);
        chk("R10 not aligned", aligned_sticky, 0);
        fire(2, 2, k);
        chk("R10 group completes", k, 33);
        chk("R10 arm cleared", arm_status, 0);
        chk("R10 aligned", aligned_sticky, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_period();
        t_continuous();
        t_oneshot();
        t_average();
        t_level();
        t_rearm();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule